// File: doc/BRIEF.md
# Transactional stripe access tracker

This block remembers which memory stripes the current transaction has already read or written. A stripe is an aligned block of memory whose size is a parameter. The memory stage presents an access address together with its kind, load or store. A combinational lookup then reports whether a record for that stripe and that kind already exists. When the lookup misses, the trigger logic can ask for an insert. The insert port writes the record in one cycle, unless the instruction has been classified as one that touches a new stripe on every occurrence.

Records are keyed on the stripe address plus the access kind. An earlier read of a stripe therefore does not satisfy a later write to that stripe. A transaction-start pulse or a context-switch flush empties the table. When every slot is in use, new records are dropped and a sticky overflow flag reports the loss until the next clear.

Top module: `stripe_tracker`

## Requirements
- R1: The stripe address is the access address shifted right by log2(STRIPE_BYTES) (default 64 bytes, so bits [5:0] are ignored). Addresses 0x17F and 0x140 fall in the same stripe; 0x180 falls in the next one.
- R2: `lk_hit_o` is 1 only if a stored record matches both the stripe and the access kind. Kind 0 means load or read, and kind 1 means store or write. A load never hits a write record, and a store never hits a read record.
- R3: A record is written only when `ins_req_i` is 1 and `ins_pred_i` is not 2'b11. With `ins_pred_i` equal to 2'b11, or with `ins_req_i` at 0, the table is unchanged.
- R4: The lookup is combinational over the stored records. An inserted record is visible from the cycle after the insert, not during the insert cycle itself.
- R5: A high `tx_start_i` or `ctx_flush_i` at a clock edge removes every record and clears `overflow_o`. A clear takes priority over an insert in the same cycle.
- R6: With all DEPTH slots in use, an insert of a new record is dropped and `overflow_o` goes to 1 and stays there until a clear. A lookup of the dropped record misses.
- R7: An insert of a record that already exists creates no second copy, so it takes no slot and cannot cause overflow.
- R8: After reset the table is empty, `lk_hit_o` is 0 and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_addr_i | input | ADDR_W | Lookup access address |
| lk_store_i | input | 1 | Lookup access kind (0 load, 1 store) |
| lk_hit_o | output | 1 | Matching record exists |
| ins_req_i | input | 1 | Insert request from trigger logic |
| ins_addr_i | input | ADDR_W | Insert access address |
| ins_store_i | input | 1 | Insert access kind (0 read, 1 write) |
| ins_pred_i | input | 2 | Prediction flag of the instruction; 2'b11 inhibits insertion |
| tx_start_i | input | 1 | Transaction start, clears all records |
| ctx_flush_i | input | 1 | Context switch, clears all records |
| overflow_o | output | 1 | Sticky: an insert was dropped because the table was full |

## Verification
The hardest state to reach is a full table receiving a mix of duplicate and fresh inserts. At that point R7 and R6 pull in opposite directions: a duplicate must not raise the overflow flag, while a fresh record must raise it. The stimulus reaches this state in two ways. Directed sequences fill every slot exactly and then present both kinds of insert. The random phase also gets there, because it draws addresses from a small stripe pool and both access kinds, and it clears only rarely, so the table fills and overflows repeatedly.

// File: rtl/stripe_tracker_pkg.sv
package stripe_tracker_pkg;
  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;

  // prediction class that inhibits insertion (every-occurrence, already called)
  localparam logic [1:0] PRED_EVERY = 2'b11;
endpackage

// File: rtl/stripe_tracker_keygen.sv
module stripe_tracker_keygen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int KEY_W = ADDR_W - OFF_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              store_i,
  output logic [KEY_W-1:0]  key_o
);
  // key = {kind, stripe}
  assign key_o = {store_i, addr_i[ADDR_W-1:OFF_W]};
endmodule

// File: rtl/stripe_tracker_entry.sv
module stripe_tracker_entry #(
  parameter int KEY_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [KEY_W-1:0] lk_key_i,
  output logic             vld_o,
  output logic             lk_hit_o,
  output logic             ins_hit_o
);
  logic             vld_q;
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= 1'b0;
    else if (clr_i) vld_q <= 1'b0;
    else if (wr_i)  vld_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_q <= '0;
    else if (wr_i) key_q <= wr_key_i;
  end

  assign vld_o     = vld_q;
  assign lk_hit_o  = vld_q && (key_q == lk_key_i);
  assign ins_hit_o = vld_q && (key_q == wr_key_i);
endmodule

// File: rtl/stripe_tracker_alloc.sv
module stripe_tracker_alloc #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0] vld_i,
  output logic [DEPTH-1:0] gnt_o,
  output logic             full_o
);
  // lowest free slot wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign full_o = &vld_i;
endmodule

// File: rtl/stripe_tracker.sv
module stripe_tracker
  import stripe_tracker_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int STRIPE_BYTES = 64,
  parameter int DEPTH        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_store_i,
  output logic              lk_hit_o,
  input  logic              ins_req_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              ins_store_i,
  input  logic [1:0]        ins_pred_i,
  input  logic              tx_start_i,
  input  logic              ctx_flush_i,
  output logic              overflow_o
);
  localparam int OFF_W = $clog2(STRIPE_BYTES);
  localparam int KEY_W = ADDR_W - OFF_W + 1;

  logic [KEY_W-1:0] lk_key, ins_key;
  logic [DEPTH-1:0] vld_v, lk_hit_v, ins_hit_v, gnt_v, wr_v;
  logic             full, clr, ins_ok, ins_dup, do_wr, ovf_q;

  stripe_tracker_keygen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lk_key (
    .addr_i (lk_addr_i),
    .store_i(lk_store_i),
    .key_o  (lk_key)
  );

  stripe_tracker_keygen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ins_key (
    .addr_i (ins_addr_i),
    .store_i(ins_store_i),
    .key_o  (ins_key)
  );

  stripe_tracker_alloc #(.DEPTH(DEPTH)) u_alloc (
    .vld_i (vld_v),
    .gnt_o (gnt_v),
    .full_o(full)
  );

  assign clr     = tx_start_i || ctx_flush_i;
  assign ins_ok  = ins_req_i && (ins_pred_i != PRED_EVERY);
  assign ins_dup = |ins_hit_v;
  assign do_wr   = ins_ok && !ins_dup && !full && !clr;
  assign wr_v    = gnt_v & {DEPTH{do_wr}};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    stripe_tracker_entry #(.KEY_W(KEY_W)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .wr_i     (wr_v[g]),
      .wr_key_i (ins_key),
      .lk_key_i (lk_key),
      .vld_o    (vld_v[g]),
      .lk_hit_o (lk_hit_v[g]),
      .ins_hit_o(ins_hit_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovf_q <= 1'b0;
    else if (clr)                         ovf_q <= 1'b0;
    else if (ins_ok && !ins_dup && full)  ovf_q <= 1'b1;
  end

  assign lk_hit_o   = |lk_hit_v;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/stripe_tracker_chk.sv
module stripe_tracker_chk #(
  parameter int DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ins_req_i,
  input logic [1:0]       ins_pred_i,
  input logic             tx_start_i,
  input logic             ctx_flush_i,
  input logic             lk_hit_o,
  input logic             overflow_o,
  input logic [DEPTH-1:0] vld_i,
  input logic [DEPTH-1:0] ins_hit_i
);
  logic clr;
  assign clr = tx_start_i || ctx_flush_i;

  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!lk_hit_o && !overflow_o && (vld_i == '0)));

  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr) |=> overflow_o);

  a_r6_overflow_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!overflow_o && !clr && !(&vld_i)) |=> !overflow_o);

  a_r3_pred_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!ins_req_i || ins_pred_i == 2'b11) && !clr) |=> $stable(vld_i));

  a_r7_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ins_hit_i));
endmodule

bind stripe_tracker stripe_tracker_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ins_req_i  (ins_req_i),
  .ins_pred_i (ins_pred_i),
  .tx_start_i (tx_start_i),
  .ctx_flush_i(ctx_flush_i),
  .lk_hit_o   (lk_hit_o),
  .overflow_o (overflow_o),
  .vld_i      (vld_v),
  .ins_hit_i  (ins_hit_v)
);

// File: tb/stripe_tracker_tb.sv
module stripe_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int SBYTES     = 64;
  localparam int DEPTH      = 16;
  localparam int SHIFT      = 6;  // log2(64)

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0, ins_addr = '0;
  logic              lk_store = 1'b0, ins_store = 1'b0, ins_req = 1'b0;
  logic [1:0]        ins_pred = 2'b00;
  logic              tx_start = 1'b0, ctx_flush = 1'b0;
  logic              lk_hit, overflow;

  int checks = 0, failures = 0;

  // reference model: set of {kind, stripe}
  logic [ADDR_W:0] m_key[DEPTH];
  int              m_cnt = 0;
  bit              m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stripe_tracker #(.ADDR_W(ADDR_W), .STRIPE_BYTES(SBYTES), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_addr_i(lk_addr), .lk_store_i(lk_store), .lk_hit_o(lk_hit),
    .ins_req_i(ins_req), .ins_addr_i(ins_addr), .ins_store_i(ins_store),
    .ins_pred_i(ins_pred), .tx_start_i(tx_start), .ctx_flush_i(ctx_flush),
    .overflow_o(overflow)
  );

  function automatic logic [ADDR_W:0] mk(logic [ADDR_W-1:0] a, logic s);
    return {s, a >> SHIFT};
  endfunction

  function automatic bit m_has(logic [ADDR_W:0] k);
    for (int i = 0; i < m_cnt; i++) if (m_key[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [ADDR_W-1:0] la, logic ls,
                      logic rq, logic [ADDR_W-1:0] ia, logic is, logic [1:0] pr,
                      logic ts, logic cf);
    logic [ADDR_W:0] k;
    @(negedge clk);
    lk_addr = la; lk_store = ls; ins_req = rq; ins_addr = ia;
    ins_store = is; ins_pred = pr; tx_start = ts; ctx_flush = cf;
    #1;
    chk({tag, " lookup"}, lk_hit, m_has(mk(la, ls)));
    chk({tag, " overflow"}, overflow, m_ovf);
    @(posedge clk);
    k = mk(ia, is);
    if (ts || cf) begin
      m_cnt = 0; m_ovf = 1'b0;
    end else if (rq && pr != 2'b11 && !m_has(k)) begin
      if (m_cnt < DEPTH) begin m_key[m_cnt] = k; m_cnt++; end
      else m_ovf = 1'b1;
    end
  endtask

  task automatic idle_look(string tag, logic [ADDR_W-1:0] la, logic ls);
    step(tag, la, ls, 1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic ins(string tag, logic [ADDR_W-1:0] ia, logic is, logic [1:0] pr);
    step(tag, ia, is, 1'b1, ia, is, pr, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    #1;
    chk("R8 reset hit", lk_hit, 1'b0);
    chk("R8 reset overflow", overflow, 1'b0);
    rst_ni = 1'b1;

    // R4: insert cycle itself misses, next cycle hits
    ins("R4 same-cycle", 32'h143, 1'b0, 2'b00);
    idle_look("R4 next-cycle", 32'h143, 1'b0);
    chk("R4 visible", lk_hit, 1'b1);
    // R1: same stripe, different offset; neighbouring stripe
    idle_look("R1 same stripe", 32'h17F, 1'b0);
    chk("R1 offset 0x17F", lk_hit, 1'b1);
    idle_look("R1 next stripe", 32'h180, 1'b0);
    chk("R1 0x180", lk_hit, 1'b0);
    // R2: store does not hit read record
    idle_look("R2 kind", 32'h140, 1'b1);
    chk("R2 store vs read", lk_hit, 1'b0);
    ins("R2 add write", 32'h150, 1'b1, 2'b10);
    idle_look("R2 write", 32'h140, 1'b1);
    chk("R2 store hit", lk_hit, 1'b1);
    // R3: pred 3 inhibits
    ins("R3 inhibited", 32'h1C0, 1'b1, 2'b11);
    idle_look("R3 after", 32'h1C0, 1'b1);
    chk("R3 no record", lk_hit, 1'b0);
    // R5: clear wins over concurrent insert
    step("R5 clear+ins", 32'h200, 1'b0, 1'b1, 32'h200, 1'b0, 2'b00, 1'b1, 1'b0);
    idle_look("R5 after", 32'h200, 1'b0);
    chk("R5 insert dropped", lk_hit, 1'b0);
    idle_look("R5 old gone", 32'h140, 1'b0);
    chk("R5 cleared", lk_hit, 1'b0);
    // R7: duplicates take no slot
    for (int r = 0; r < 3; r++) ins("R7 dup", 32'h1000, 1'b0, 2'b01);
    for (int i = 1; i < DEPTH; i++) ins("R7 fill", 32'h1000 + i * SBYTES, 1'b0, 2'b00);
    ins("R7 dup when full", 32'h1000, 1'b0, 2'b00);
    idle_look("R7 check", 32'h1000, 1'b0);
    chk("R7 no overflow", overflow, 1'b0);
    // R6: table full, fresh insert dropped
    ins("R6 drop", 32'h9000, 1'b1, 2'b00);
    idle_look("R6 after", 32'h9000, 1'b1);
    chk("R6 overflow set", overflow, 1'b1);
    chk("R6 dropped misses", lk_hit, 1'b0);
    idle_look("R6 sticky", 32'h1040, 1'b0);
    chk("R6 sticky", overflow, 1'b1);
    step("R5 flush", '0, 1'b0, 1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b1);
    idle_look("R5 flush after", 32'h1040, 1'b0);
    chk("R5 flush clears overflow", overflow, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] la, ia;
      la = ($urandom_range(0, 23) << SHIFT) | $urandom_range(0, SBYTES - 1);
      ia = ($urandom_range(0, 23) << SHIFT) | $urandom_range(0, SBYTES - 1);
      step("R4 random", la, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) != 0), ia, 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)),
           1'($urandom_range(0, 79) == 0), 1'($urandom_range(0, 119) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule